// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU

This unit performs packed integer arithmetic on two 64-bit operands, treating each operand as a short vector of independent lanes. A run-time lane-size select splits the datapath into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Carries and borrows never cross a lane boundary. A signedness select chooses how lanes are interpreted for saturation, ordering and compares.

The operations are lane-wise add and subtract (wrapping or saturating), minimum, maximum, equality and greater-than compares that produce element masks, a sum of absolute differences that folds all byte lanes into one scalar, and a signed multiply-add that multiplies 16-bit lanes and sums adjacent products into 32-bit words. Every result is registered: it appears one clock after the cycle in which `inValid` is high, together with `outValid`. The unit keeps no state except this output register. It signals no exceptions. An unsupported combination returns zero and raises a one-cycle status bit.

Top module: `simd_lane_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `result`, `outValid` and `illegalOp` to zero.
- R2: The clock edge that samples `inValid` high loads `result` and sets `outValid`. `outValid` is low after an edge that samples `inValid` low, and `result` then keeps its previous value. `illegalOp` is high only in the cycle after an illegal valid request.
- R3: `laneSize` 0, 1 and 2 select 8-, 16- and 32-bit lanes. Opcode 0 (add) and opcode 1 (subtract) wrap within each lane, and no carry or borrow crosses a lane boundary.
- R4: With `signedMode`=1, opcode 2 (saturating add) and opcode 3 (saturating subtract) clamp each lane to the range -2^(W-1) to 2^(W-1)-1, where W is the lane width.
- R5: With `signedMode`=0, opcodes 2 and 3 clamp each lane to the range 0 to 2^W-1.
- R6: Opcode 4 returns the per-lane minimum and opcode 5 the per-lane maximum. The ordering is signed when `signedMode`=1 and unsigned otherwise.
- R7: Opcode 6 (equal) and opcode 7 (greater-than, with A compared to B and ordered by `signedMode`) set each lane to all ones when the condition holds and to all zeros otherwise.
- R8: Opcode 8 (sum of absolute differences) needs 8-bit unsigned lanes. It places the sum of all eight byte-lane absolute differences in `result[15:0]` and sets `result[63:16]` to zero.
- R9: Opcode 9 (multiply-add) needs 16-bit signed lanes. `result[31:0]` is the product of lane 0 plus the product of lane 1, and `result[63:32]` is the same for lanes 2 and 3. Each sum wraps to 32 bits.
- R10: Opcodes 10 to 15, `laneSize`=3, opcode 8 outside 8-bit unsigned mode, and opcode 9 outside 16-bit signed mode are illegal. Each returns a zero result and raises `illegalOp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe; the operands and controls are sampled when it is high |
| opCode | input | 4 | Operation select (0..9 are legal) |
| laneSize | input | 2 | Lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits |
| signedMode | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Registered packed result |
| illegalOp | output | 1 | Unsupported combination flag for the current result |

## Verification
Any fault in lane decoding, such as a wrong one-hot width select or a carry leaking between lanes, shows in the very next `result` as a corrupted neighbouring lane. The vectors therefore place boundary values next to zeroed lanes. Saturation and ordering faults appear as a wrong clamp value or a wrong min/max choice one cycle after the request, and each mode is checked with both signed and unsigned operands. A stale or wrongly loaded output register shows either as a `result` that changes while `inValid` is low, or as an `illegalOp` that stays high beyond its single cycle.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int DATA_W        = 64;
  localparam int MIN_LANE_W    = 8;
  localparam int LANE_VARIANTS = 3;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDS  = 4'd2,
    OP_SUBS  = 4'd3,
    OP_MIN   = 4'd4,
    OP_MAX   = 4'd5,
    OP_CMPEQ = 4'd6,
    OP_CMPGT = 4'd7,
    OP_SAD   = 4'd8,
    OP_MADD  = 4'd9
  } opCodeT;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2
  } laneSizeT;

  typedef enum logic [2:0] {
    K_ARITH = 3'd0,
    K_MIN   = 3'd1,
    K_MAX   = 3'd2,
    K_EQ    = 3'd3,
    K_GT    = 3'd4,
    K_SAD   = 3'd5,
    K_MADD  = 3'd6,
    K_NONE  = 3'd7
  } kindT;

  typedef struct packed {
    kindT                     kind;
    logic                     subtract;
    logic                     saturate;
    logic                     signedLanes;
    logic [LANE_VARIANTS-1:0] widthSel;
    logic                     illegal;
  } ctrlStrobesT;

endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  opCode,
  input  logic [1:0]  laneSize,
  input  logic        signedMode,
  output ctrlStrobesT strobes
);

  logic badWidth;
  logic badOp;

  always_comb begin
    strobes             = '0;
    strobes.kind        = K_NONE;
    strobes.signedLanes = signedMode;
    badWidth            = (laneSize > LANE_32);
    badOp               = 1'b0;
    if (!badWidth) strobes.widthSel = LANE_VARIANTS'(1) << laneSize;

    case (opCode)
      OP_ADD:   strobes.kind = K_ARITH;
      OP_SUB:   begin strobes.kind = K_ARITH; strobes.subtract = 1'b1; end
      OP_ADDS:  begin strobes.kind = K_ARITH; strobes.saturate = 1'b1; end
      OP_SUBS:  begin
                  strobes.kind     = K_ARITH;
                  strobes.subtract = 1'b1;
                  strobes.saturate = 1'b1;
                end
      OP_MIN:   strobes.kind = K_MIN;
      OP_MAX:   strobes.kind = K_MAX;
      OP_CMPEQ: strobes.kind = K_EQ;
      OP_CMPGT: strobes.kind = K_GT;
      OP_SAD:   begin
                  strobes.kind = K_SAD;
                  badOp = (laneSize != LANE_8) || signedMode;
                end
      OP_MADD:  begin
                  strobes.kind = K_MADD;
                  badOp = (laneSize != LANE_16) || !signedMode;
                end
      default:  badOp = 1'b1;
    endcase

    strobes.illegal = badOp || badWidth;
    if (strobes.illegal) begin
      strobes.kind     = K_NONE;
      strobes.widthSel = '0;
    end
  end

  // R3: a legal request selects exactly one lane width
  p_width_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    !strobes.illegal |-> $countones(strobes.widthSel) == 1);

  // R8: the reduction over bytes is issued only for unsigned 8-bit lanes
  p_sad_mode_r8: assert property (@(posedge clk) disable iff (rst)
    strobes.kind == K_SAD |-> (laneSize == 2'd0) && !signedMode);

  // R9: multiply-add is issued only for signed 16-bit lanes
  p_madd_mode_r9: assert property (@(posedge clk) disable iff (rst)
    strobes.kind == K_MADD |-> (laneSize == 2'd1) && signedMode);

endmodule

// File: rtl/simd_lane_slice.sv
module simd_lane_slice
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] laneA,
  input  logic [W-1:0] laneB,
  input  kindT         kind,
  input  logic         subtract,
  input  logic         saturate,
  input  logic         signedLanes,
  output logic [W-1:0] laneRes
);

  localparam int EW = W + 2;

  logic [EW-1:0] extA;
  logic [EW-1:0] extB;
  logic [EW-1:0] sum;
  logic [W-1:0]  satRes;
  logic          aGreater;
  logic          aEqual;

  always_comb begin
    extA = signedLanes ? {{2{laneA[W-1]}}, laneA} : {2'b00, laneA};
    extB = signedLanes ? {{2{laneB[W-1]}}, laneB} : {2'b00, laneB};
    sum  = subtract ? (extA - extB) : (extA + extB);
    aGreater = $signed(extA) > $signed(extB);
    aEqual   = (laneA == laneB);
  end

  always_comb begin
    if (signedLanes) begin
      if (sum[W+1:W-1] == 3'b000 || sum[W+1:W-1] == 3'b111)
        satRes = sum[W-1:0];
      else if (sum[W+1])
        satRes = {1'b1, {(W-1){1'b0}}};
      else
        satRes = {1'b0, {(W-1){1'b1}}};
    end else begin
      if (sum[W+1])      satRes = '0;
      else if (sum[W])   satRes = '1;
      else               satRes = sum[W-1:0];
    end
  end

  always_comb begin
    case (kind)
      K_ARITH: laneRes = saturate ? satRes : sum[W-1:0];
      K_MIN:   laneRes = aGreater ? laneB : laneA;
      K_MAX:   laneRes = aGreater ? laneA : laneB;
      K_EQ:    laneRes = {W{aEqual}};
      K_GT:    laneRes = {W{aGreater}};
      default: laneRes = '0;
    endcase
  end

endmodule

// File: rtl/simd_alu_datapath.sv
module simd_alu_datapath
  import simd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  ctrlStrobesT       strobes,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);

  localparam int BYTE_LANES = DATA_W / MIN_LANE_W;
  localparam int SAD_W      = $clog2(BYTE_LANES * ((1 << MIN_LANE_W) - 1) + 1);
  localparam int MADD_IN_W  = 2 * MIN_LANE_W;
  localparam int MADD_OUT_W = 2 * MADD_IN_W;
  localparam int MADD_LANES = DATA_W / MADD_IN_W;
  localparam int MADD_PAIRS = MADD_LANES / 2;

  logic [DATA_W-1:0] laneOut [LANE_VARIANTS];
  logic [DATA_W-1:0] laneSel;
  logic [SAD_W-1:0]  sadSum;
  logic [DATA_W-1:0] maddRes;
  logic [DATA_W-1:0] nextResult;

  for (genvar g = 0; g < LANE_VARIANTS; g++) begin : g_width
    localparam int W = MIN_LANE_W << g;
    localparam int N = DATA_W / W;
    logic [DATA_W-1:0] variantRes;
    for (genvar l = 0; l < N; l++) begin : g_lane
      simd_lane_slice #(.W(W)) i_slice (
        .laneA       (opA[l*W +: W]),
        .laneB       (opB[l*W +: W]),
        .kind        (strobes.kind),
        .subtract    (strobes.subtract),
        .saturate    (strobes.saturate),
        .signedLanes (strobes.signedLanes),
        .laneRes     (variantRes[l*W +: W])
      );
    end
    assign laneOut[g] = variantRes;
  end

  always_comb begin
    laneSel = '0;
    for (int g = 0; g < LANE_VARIANTS; g++)
      if (strobes.widthSel[g]) laneSel = laneOut[g];
  end

  always_comb begin
    logic [MIN_LANE_W-1:0] ba, bb;
    sadSum = '0;
    for (int i = 0; i < BYTE_LANES; i++) begin
      ba = opA[i*MIN_LANE_W +: MIN_LANE_W];
      bb = opB[i*MIN_LANE_W +: MIN_LANE_W];
      sadSum = sadSum + SAD_W'((ba > bb) ? (ba - bb) : (bb - ba));
    end
  end

  always_comb begin
    logic signed [MADD_OUT_W-1:0] prodLo, prodHi;
    maddRes = '0;
    for (int p = 0; p < MADD_PAIRS; p++) begin
      prodLo = $signed(opA[(2*p)*MADD_IN_W +: MADD_IN_W]) *
               $signed(opB[(2*p)*MADD_IN_W +: MADD_IN_W]);
      prodHi = $signed(opA[(2*p+1)*MADD_IN_W +: MADD_IN_W]) *
               $signed(opB[(2*p+1)*MADD_IN_W +: MADD_IN_W]);
      maddRes[p*MADD_OUT_W +: MADD_OUT_W] = prodLo + prodHi;
    end
  end

  always_comb begin
    case (strobes.kind)
      K_SAD:   nextResult = DATA_W'(sadSum);
      K_MADD:  nextResult = maddRes;
      K_NONE:  nextResult = '0;
      default: nextResult = laneSel;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
      result    <= '0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid && strobes.illegal;
      if (inValid) result <= nextResult;
    end
  end

  logic maskUniform;
  always_comb begin
    maskUniform = 1'b1;
    for (int i = 0; i < BYTE_LANES; i++)
      if (result[i*MIN_LANE_W +: MIN_LANE_W] != '0 &&
          result[i*MIN_LANE_W +: MIN_LANE_W] != '1)
        maskUniform = 1'b0;
  end

  // R2: valid output exactly one cycle after a request
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> outValid == $past(inValid));

  // R2: the output register holds without a request
  p_hold_result_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inValid)) |-> $stable(result));

  // R10: an illegal request yields a zero, valid result
  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> (result == '0) && outValid);

  // R8: upper bits of the reduction result are zero
  p_sad_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && outValid && $past(strobes.kind) == K_SAD) |->
      result[DATA_W-1:16] == '0);

  // R7: compare masks are all-ones or all-zeros per byte
  p_mask_uniform_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && outValid &&
     ($past(strobes.kind) == K_EQ || $past(strobes.kind) == K_GT)) |->
      maskUniform);

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [3:0]  opCode,
  input  logic [1:0]  laneSize,
  input  logic        signedMode,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  output logic        outValid,
  output logic [63:0] result,
  output logic        illegalOp
);

  ctrlStrobesT strobes;

  simd_alu_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opCode     (opCode),
    .laneSize   (laneSize),
    .signedMode (signedMode),
    .strobes    (strobes)
  );

  simd_alu_datapath i_datapath (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .opA       (opA),
    .opB       (opB),
    .strobes   (strobes),
    .outValid  (outValid),
    .result    (result),
    .illegalOp (illegalOp)
  );

endmodule

// File: tb/test_simd_lane_alu.sv
`timescale 1ns/1ps
module test_simd_lane_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [1:0]  laneSize = '0;
  logic        signedMode = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;
  logic        illegalOp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  simd_lane_alu i_simd_lane_alu (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .laneSize(laneSize), .signedMode(signedMode), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .illegalOp(illegalOp)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  lane;
    logic        sgn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vecT;

  localparam int NVEC = 20;
  localparam vecT VECS [NVEC] = '{
    // R3 wrapping add, 8-bit lanes: byte1 wraps, no carry into byte2
    '{4'd0, 2'd0, 1'b0, 64'h0000_0000_0000_FF01, 64'h0000_0000_0000_0101, 64'h0000_0000_0000_0002, 1'b0, 4'd3},
    // R3 wrapping add, 16-bit lanes
    '{4'd0, 2'd1, 1'b0, 64'h0000_0001_FFFF_1234, 64'h0000_0000_0001_0001, 64'h0000_0001_0000_1235, 1'b0, 4'd3},
    // R3 wrapping subtract, 32-bit lanes: no borrow into high word
    '{4'd1, 2'd2, 1'b0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0001_FFFF_FFFF, 1'b0, 4'd3},
    // R4 signed saturating add, 8-bit lanes
    '{4'd2, 2'd0, 1'b1, 64'h0000_0000_F010_807F, 64'h0000_0000_F020_FF01, 64'h0000_0000_E030_807F, 1'b0, 4'd4},
    // R4 signed saturating subtract, 16-bit lanes
    '{4'd3, 2'd1, 1'b1, 64'h0000_0005_7FFF_8000, 64'h0000_0007_FFFF_0001, 64'h0000_FFFE_7FFF_8000, 1'b0, 4'd4},
    // R5 unsigned saturating add, 8-bit lanes
    '{4'd2, 2'd0, 1'b0, 64'h0000_0000_0000_10FF, 64'h0000_0000_0000_2002, 64'h0000_0000_0000_30FF, 1'b0, 4'd5},
    // R5 unsigned saturating subtract, 32-bit lanes
    '{4'd3, 2'd2, 1'b0, 64'h0000_0009_0000_0005, 64'h0000_0003_0000_0007, 64'h0000_0006_0000_0000, 1'b0, 4'd5},
    // R6 signed minimum, 8-bit lanes
    '{4'd4, 2'd0, 1'b1, 64'h0000_0000_0000_0180, 64'h0000_0000_0000_027F, 64'h0000_0000_0000_0180, 1'b0, 4'd6},
    // R6 unsigned maximum, 8-bit lanes
    '{4'd5, 2'd0, 1'b0, 64'h0000_0000_0000_0180, 64'h0000_0000_0000_027F, 64'h0000_0000_0000_0280, 1'b0, 4'd6},
    // R6 signed maximum, 16-bit lanes
    '{4'd5, 2'd1, 1'b1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0, 4'd6},
    // R7 equality mask, 16-bit lanes
    '{4'd6, 2'd1, 1'b0, 64'h1111_2222_3333_4444, 64'h1111_0000_3333_4445, 64'hFFFF_0000_FFFF_0000, 1'b0, 4'd7},
    // R7 signed greater-than mask, 8-bit lanes
    '{4'd7, 2'd0, 1'b1, 64'h0000_0000_0000_0180, 64'h0000_0000_0000_007F, 64'h0000_0000_0000_FF00, 1'b0, 4'd7},
    // R7 unsigned greater-than mask, 8-bit lanes
    '{4'd7, 2'd0, 1'b0, 64'h0000_0000_0000_0180, 64'h0000_0000_0000_007F, 64'h0000_0000_0000_FFFF, 1'b0, 4'd7},
    // R8 sum of absolute differences: 255 + 255 + 5
    '{4'd8, 2'd0, 1'b0, 64'h0A00_0000_0000_00FF, 64'h0F00_0000_0000_FF00, 64'h0000_0000_0000_0203, 1'b0, 4'd8},
    // R9 multiply-add: 2*3 + (-1)*4, and a high sum that wraps
    '{4'd9, 2'd1, 1'b1, 64'h8000_8000_FFFF_0002, 64'h8000_8000_0004_0003, 64'h8000_0000_0000_0002, 1'b0, 4'd9},
    // R10 undefined opcode
    '{4'd12, 2'd0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 64'h0, 1'b1, 4'd10},
    // R10 lane size 3
    '{4'd0, 2'd3, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0, 1'b1, 4'd10},
    // R10 sum of absolute differences with 16-bit lanes
    '{4'd8, 2'd1, 1'b0, 64'h0000_0000_0000_00FF, 64'h0, 64'h0, 1'b1, 4'd10},
    // R10 multiply-add with unsigned lanes
    '{4'd9, 2'd1, 1'b0, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0003, 64'h0, 1'b1, 4'd10},
    // R10 sum of absolute differences with signed lanes
    '{4'd8, 2'd0, 1'b1, 64'h0000_0000_0000_00FF, 64'h0, 64'h0, 1'b1, 4'd10}
  };

  task automatic checkVal(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [1:0] lane, logic sgn, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    opCode = op; laneSize = lane; signedMode = sgn; opA = a; opB = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkVal("R1", "result", result, 64'h0);
    checkVal("R1", "outValid", {63'h0, outValid}, 64'h0);
    checkVal("R1", "illegalOp", {63'h0, illegalOp}, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      issue(VECS[i].op, VECS[i].lane, VECS[i].sgn, VECS[i].a, VECS[i].b);
      checkVal(tag, "result", result, VECS[i].exp);
      checkVal(tag, "illegalOp", {63'h0, illegalOp}, {63'h0, VECS[i].ill});
      checkVal("R2", "outValid", {63'h0, outValid}, 64'h1);
    end

    // R2: hold without request, illegal flag lasts one cycle
    issue(4'd0, 2'd0, 1'b0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003);
    checkVal("R2", "result", result, 64'h8);
    opA = 64'hFFFF_FFFF_FFFF_FFFF; opB = 64'h1; opCode = 4'd15;
    @(negedge clk);
    checkVal("R2", "held result", result, 64'h8);
    checkVal("R2", "outValid low", {63'h0, outValid}, 64'h0);
    issue(4'd14, 2'd0, 1'b0, 64'h0, 64'h0);
    checkVal("R10", "illegalOp set", {63'h0, illegalOp}, 64'h1);
    @(negedge clk);
    checkVal("R2", "illegalOp one cycle", {63'h0, illegalOp}, 64'h0);

    // R1: reset in mid-run clears a nonzero result
    issue(4'd1, 2'd2, 1'b0, 64'h0000_0000_0000_0009, 64'h0000_0000_0000_0002);
    checkVal("R3", "result", result, 64'h7);
    rst = 1'b1;
    @(negedge clk);
    checkVal("R1", "result after reset", result, 64'h0);
    checkVal("R1", "outValid after reset", {63'h0, outValid}, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule